// File: doc/BRIEF.md
# Page-Bounded Flash Program Splitter

This block accepts one byte-program request at a time, given as a start offset and a byte count, for a flash device whose pages are a power of two in size. It cuts the request into chunks that each stay inside a single page. For each chunk it issues one program command to a downstream command engine. It waits for that engine to report completion before it issues the next chunk. The payload bytes arrive on an upstream valid/ready stream. The block forwards them unchanged to the engine's data stream, and lets through exactly as many bytes as the current chunk holds.

Before any command goes out, the block checks that the request fits inside the device. It also drives an active-low write-protect output. Protection is lifted for the whole multi-chunk sequence and restored once the sequence ends, whether it ends normally or with an error. Page size, device size and the choice of program opcode are parameters. Serial signalling to the flash is left to the downstream engine.

Top module: `flash_write_splitter`

## Requirements
- R1: When offset + length is larger than CHIP_BYTES, the block answers with done and done_err both high in the cycle after acceptance. It issues no command, and wp_n stays low.
- R2: A request of length zero is answered with done high and done_err low in the cycle after acceptance. It issues no command, and wp_n stays low.
- R3: The first command's cmd_addr equals the request offset. Each later command's address equals the previous address plus the previous cmd_len.
- R4: Each cmd_len equals the smaller of the bytes still to be written and the page size minus (cmd_addr modulo page size). A chunk therefore never crosses a page boundary and is never zero.
- R5: The cmd_len values of a request without errors add up to the request length. After the command that covers the last byte, done follows with done_err low.
- R6: cmd_opcode is 8'h02 when USE_RMW is 0. It is 8'h58 when USE_RMW is 1.
- R7: At most one command is outstanding. cmd_valid stays low from the accepting cycle until cmd_done has been seen for that command.
- R8: wp_n is low while idle and in the done cycle. It is high whenever a command is offered or a payload byte is passed.
- R9: A cmd_done that comes with cmd_err high ends the request. No further command is issued, and done comes with done_err high.
- R10: After each command is accepted, exactly cmd_len payload bytes pass from src to dst, in order and unchanged. No byte passes outside a chunk.
- R11: done is a single-cycle pulse. req_ready is high only while idle, so it is low whenever a command is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_offset | input | ADDR_W | Start byte offset |
| req_len | input | LEN_W | Number of bytes to write |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request failed (range or engine error), valid with done |
| cmd_valid | output | 1 | Program command offered |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_opcode | output | 8 | Program opcode |
| cmd_addr | output | ADDR_W | Chunk start address |
| cmd_len | output | CLEN_W | Chunk byte count |
| cmd_done | input | 1 | Engine finished the outstanding chunk |
| cmd_err | input | 1 | Chunk failed, valid with cmd_done |
| src_valid | input | 1 | Upstream payload byte valid |
| src_ready | output | 1 | Upstream payload byte taken |
| src_data | input | 8 | Upstream payload byte |
| dst_valid | output | 1 | Payload byte offered to engine |
| dst_ready | input | 1 | Engine takes payload byte |
| dst_data | output | 8 | Payload byte to engine |
| wp_n | output | 1 | Active-low write protect |

## Verification
The splitter is driven with several request shapes. A page-aligned full page must give exactly one chunk. A short request inside one page must keep its unaligned address. A request that starts mid-page and spans three pages shows whether the head, middle and tail chunks are sized independently. A whole-device request checks that the offset walks to the end of the address space. Requests that end exactly at the device boundary and one byte past it separate a correct range test from an off-by-one. A zero-length request shows that the block finishes without opening write protect. An engine error on the second chunk of a multi-page request shows whether the sequence stops early and still restores protection.

// File: rtl/flash_split_pkg.sv
package flash_split_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } split_state_e;

  localparam logic [7:0] OP_PROG_BUF = 8'h02;
  localparam logic [7:0] OP_PROG_RMW = 8'h58;

endpackage

// File: rtl/flash_range_check.sv
module flash_range_check #(
  parameter int CHIP_BYTES = 65536,
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 17
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [LEN_W-1:0]  length,
  output logic              fits
);
  localparam int SUM_W = ADDR_W + 2;

  logic [SUM_W-1:0] end_pos;

  always_comb begin
    end_pos = SUM_W'(offset) + SUM_W'(length);
    fits    = (end_pos <= SUM_W'(CHIP_BYTES));
  end

endmodule

// File: rtl/flash_chunk_calc.sv
module flash_chunk_calc #(
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 17,
  localparam int PAGE_LOG  = $clog2(PAGE_BYTES),
  localparam int CLEN_W    = PAGE_LOG + 1
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  remaining,
  output logic [CLEN_W-1:0] chunk_len
);
  logic [CLEN_W-1:0] room;

  always_comb begin
    // distance from the current address to the next page boundary
    room = CLEN_W'(PAGE_BYTES) - CLEN_W'(cur_addr[PAGE_LOG-1:0]);
    if (remaining < LEN_W'(room)) begin
      chunk_len = remaining[CLEN_W-1:0];
    end else begin
      chunk_len = room;
    end
  end

endmodule

// File: rtl/flash_byte_gate.sv
module flash_byte_gate #(
  parameter int CLEN_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CLEN_W-1:0] load_len,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic [CLEN_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic              open;
  logic              xfer;

  always_comb begin
    open     = (cnt_q != '0);
    dn_valid = up_valid && open;
    up_ready = dn_ready && open;
    dn_data  = up_data;
    xfer     = dn_valid && dn_ready;
    cnt_en   = load || xfer;
    cnt_d    = load ? load_len : (cnt_q - CLEN_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // a new chunk may only be loaded once the previous one has drained
  assert_gate_drained_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0));

endmodule

// File: rtl/flash_write_splitter.sv
module flash_write_splitter
  import flash_split_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int CHIP_BYTES = 65536,
  parameter bit USE_RMW    = 1'b0,
  localparam int ADDR_W    = $clog2(CHIP_BYTES),
  localparam int LEN_W     = ADDR_W + 1,
  localparam int PAGE_LOG  = $clog2(PAGE_BYTES),
  localparam int CLEN_W    = PAGE_LOG + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [LEN_W-1:0]  req_len,
  output logic              done,
  output logic              done_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_opcode,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CLEN_W-1:0] cmd_len,
  input  logic              cmd_done,
  input  logic              cmd_err,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [7:0]        src_data,
  output logic              dst_valid,
  input  logic              dst_ready,
  output logic [7:0]        dst_data,
  output logic              wp_n
);
  localparam logic [7:0] PROG_OP = USE_RMW ? OP_PROG_RMW : OP_PROG_BUF;

  split_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [CLEN_W-1:0] chunk_q, chunk_d;
  logic              err_q, err_d;
  logic              wp_n_q, wp_n_d;
  logic              ctx_en, chunk_en;
  logic              fits;
  logic [CLEN_W-1:0] chunk_len;
  logic              issue_fire;

  flash_range_check #(
    .CHIP_BYTES (CHIP_BYTES),
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W)
  ) u_range (
    .offset (req_offset),
    .length (req_len),
    .fits   (fits)
  );

  flash_chunk_calc #(
    .PAGE_BYTES (PAGE_BYTES),
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W)
  ) u_chunk (
    .cur_addr  (addr_q),
    .remaining (rem_q),
    .chunk_len (chunk_len)
  );

  flash_byte_gate #(
    .CLEN_W (CLEN_W),
    .DATA_W (8)
  ) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue_fire),
    .load_len (chunk_len),
    .up_valid (src_valid),
    .up_ready (src_ready),
    .up_data  (src_data),
    .dn_valid (dst_valid),
    .dn_ready (dst_ready),
    .dn_data  (dst_data)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    rem_d      = rem_q;
    chunk_d    = chunk_q;
    err_d      = err_q;
    ctx_en     = 1'b0;
    chunk_en   = 1'b0;
    req_ready  = (state_q == ST_IDLE);
    cmd_valid  = (state_q == ST_ISSUE);
    done       = (state_q == ST_RESP);
    issue_fire = cmd_valid && cmd_ready;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ctx_en = 1'b1;
          addr_d = req_offset;
          rem_d  = req_len;
          if (!fits) begin
            err_d   = 1'b1;
            state_d = ST_RESP;
          end else if (req_len == '0) begin
            err_d   = 1'b0;
            state_d = ST_RESP;
          end else begin
            err_d   = 1'b0;
            state_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (issue_fire) begin
          chunk_en = 1'b1;
          chunk_d  = chunk_len;
          state_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cmd_done) begin
          if (cmd_err) begin
            ctx_en  = 1'b1;
            err_d   = 1'b1;
            state_d = ST_RESP;
          end else begin
            ctx_en = 1'b1;
            addr_d = addr_q + ADDR_W'(chunk_q);
            rem_d  = rem_q - LEN_W'(chunk_q);
            state_d = (rem_q == LEN_W'(chunk_q)) ? ST_RESP : ST_ISSUE;
          end
        end
      end
      ST_RESP: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    wp_n_d = (state_d == ST_ISSUE) || (state_d == ST_WAIT);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wp_n_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wp_n_q  <= wp_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      err_q  <= 1'b0;
    end else if (ctx_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chunk_q <= '0;
    end else if (chunk_en) begin
      chunk_q <= chunk_d;
    end
  end

  assign cmd_opcode = PROG_OP;
  assign cmd_addr   = addr_q;
  assign cmd_len    = chunk_len;
  assign done_err   = err_q;
  assign wp_n       = wp_n_q;

  assert_range_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !fits) |=> (done && done_err && !wp_n));

  assert_zero_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && fits && req_len == '0) |=> (done && !done_err && !wp_n));

  assert_chunk_in_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len != '0 && LEN_W'(cmd_len) <= rem_q &&
                   (CLEN_W'(cmd_addr[PAGE_LOG-1:0]) + cmd_len) <= CLEN_W'(PAGE_BYTES)));

  assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  assert_wp_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || dst_valid) |-> wp_n);

  assert_err_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && cmd_done && cmd_err) |=> (done && done_err && !cmd_valid));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

endmodule

// File: tb/flash_write_splitter_tb.sv
module flash_write_splitter_tb;
  localparam int PAGE   = 16;
  localparam int CHIP   = 256;
  localparam int ADDR_W = $clog2(CHIP);
  localparam int LEN_W  = ADDR_W + 1;
  localparam int CLEN_W = $clog2(PAGE) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_offset = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              cmd_ready = 1'b1;
  logic              cmd_done = 1'b0;
  logic              cmd_err = 1'b0;
  logic              src_valid = 1'b1;
  logic [7:0]        src_data = 8'd0;
  logic              dst_ready = 1'b1;

  logic              req_ready, done, done_err, cmd_valid, src_ready, dst_valid, wp_n;
  logic [7:0]        cmd_opcode, dst_data;
  logic [ADDR_W-1:0] cmd_addr;
  logic [CLEN_W-1:0] cmd_len;

  logic              r_req_ready, r_done, r_done_err, r_cmd_valid, r_src_ready, r_dst_valid, r_wp_n;
  logic [7:0]        r_cmd_opcode, r_dst_data;
  logic [ADDR_W-1:0] r_cmd_addr;
  logic [CLEN_W-1:0] r_cmd_len;

  flash_write_splitter #(.PAGE_BYTES(PAGE), .CHIP_BYTES(CHIP), .USE_RMW(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_len(req_len), .done(done), .done_err(done_err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data), .wp_n(wp_n));

  flash_write_splitter #(.PAGE_BYTES(PAGE), .CHIP_BYTES(CHIP), .USE_RMW(1'b1)) u_dut_rmw (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r_req_ready),
    .req_offset(req_offset), .req_len(req_len), .done(r_done), .done_err(r_done_err),
    .cmd_valid(r_cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(r_cmd_opcode),
    .cmd_addr(r_cmd_addr), .cmd_len(r_cmd_len), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .src_valid(src_valid), .src_ready(r_src_ready), .src_data(src_data),
    .dst_valid(r_dst_valid), .dst_ready(dst_ready), .dst_data(r_dst_data), .wp_n(r_wp_n));

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // engine model and monitors
  int        ncmd, err_at, need, got, total, wp_hi;
  int        v_overlap, v_rdy, v_wp, v_data, v_stray, v_rmw;
  bit        busy = 1'b0;
  logic [7:0] exp_byte = 8'd0;
  logic [7:0] rec_op [0:31];
  int        rec_addr [0:31];
  int        rec_len [0:31];

  always @(posedge clk) if (src_valid && src_ready) src_data <= src_data + 8'd1;

  always @(negedge clk) begin
    if (cmd_done) begin cmd_done = 1'b0; cmd_err = 1'b0; end
    if (wp_n) wp_hi++;
    if (r_cmd_valid && r_cmd_opcode != 8'h58) v_rmw++;
    if (cmd_valid) begin
      if (busy) v_overlap++;
      if (req_ready) v_rdy++;
      if (!wp_n) v_wp++;
      if (ncmd < 32) begin
        rec_op[ncmd] = cmd_opcode; rec_addr[ncmd] = int'(cmd_addr); rec_len[ncmd] = int'(cmd_len);
      end
      ncmd++;
      busy = 1'b1; need = int'(cmd_len); got = 0;
    end else if (busy) begin
      if (dst_valid && dst_ready) begin
        if (dst_data != exp_byte) v_data++;
        if (!wp_n) v_wp++;
        exp_byte = exp_byte + 8'd1; got++; total++;
      end else if (got == need) begin
        cmd_done = 1'b1;
        cmd_err  = ((ncmd - 1) == err_at);
        busy = 1'b0;
      end
    end else if (dst_valid) v_stray++;
  end

  task automatic run_req(input int off, input int len, input int e_at, input string tag);
    int x_addr [0:31];
    int x_len [0:31];
    int nexp, o, r, c, sum, wait_n;
    bit x_err;
    @(negedge clk);
    ncmd = 0; total = 0; wp_hi = 0; err_at = e_at;
    v_overlap = 0; v_rdy = 0; v_wp = 0; v_data = 0; v_stray = 0; v_rmw = 0;
    // expected chunk list from the requirement formulas
    nexp = 0; sum = 0; x_err = 1'b0;
    if (off + len > CHIP) x_err = 1'b1;
    else begin
      o = off; r = len;
      while (r > 0) begin
        c = PAGE - (o % PAGE);
        if (r < c) c = r;
        x_addr[nexp] = o; x_len[nexp] = c; sum += c;
        if (nexp == e_at) begin x_err = 1'b1; nexp++; break; end
        nexp++; o += c; r -= c;
      end
    end
    check(req_ready == 1'b1 && wp_n == 1'b0, {tag, " R8 idle wp_n low, R11 ready"}, int'(wp_n), 0);
    req_offset = ADDR_W'(off); req_len = LEN_W'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 5000) begin @(negedge clk); wait_n++; end
    check(done == 1'b1, {tag, " R5 done seen"}, int'(done), 1);
    check(done_err == x_err, {tag, " R1/R9 done_err"}, int'(done_err), int'(x_err));
    check(wp_n == 1'b0, {tag, " R8 wp_n low at done"}, int'(wp_n), 0);
    check(ncmd == nexp, {tag, " R5/R9 command count"}, ncmd, nexp);
    for (int i = 0; i < nexp && i < ncmd; i++) begin
      check(rec_addr[i] == x_addr[i], {tag, " R3 chunk address"}, rec_addr[i], x_addr[i]);
      check(rec_len[i] == x_len[i], {tag, " R4 chunk length"}, rec_len[i], x_len[i]);
      check(rec_op[i] == 8'h02, {tag, " R6 opcode"}, int'(rec_op[i]), 2);
    end
    check(total == sum, {tag, " R10 bytes passed"}, total, sum);
    check(v_data == 0 && v_stray == 0, {tag, " R10 data order/stray"}, v_data + v_stray, 0);
    check(v_overlap == 0, {tag, " R7 overlap"}, v_overlap, 0);
    check(v_wp == 0, {tag, " R8 wp_n while active"}, v_wp, 0);
    check(v_rdy == 0, {tag, " R11 req_ready while busy"}, v_rdy, 0);
    check(v_rmw == 0, {tag, " R6 rmw opcode 0x58"}, v_rmw, 0);
    if (nexp == 0)
      check(wp_hi == 0, {tag, " R1/R2 wp_n never released"}, wp_hi, 0);
    @(negedge clk);
    check(done == 1'b0 && req_ready == 1'b1, {tag, " R11 done single pulse"}, int'(done), 0);
  endtask

  task automatic t_aligned_page();   run_req(0, 16, -1, "aligned");        endtask
  task automatic t_inside_page();    run_req(3, 5, -1, "inside");          endtask
  task automatic t_cross_pages();    run_req(10, 30, -1, "cross");         endtask
  task automatic t_whole_chip();     run_req(0, 256, -1, "whole");         endtask
  task automatic t_zero_len();       run_req(20, 0, -1, "zero_R2");        endtask
  task automatic t_range_edge();     run_req(240, 16, -1, "edge_fit");     endtask
  task automatic t_range_over();     run_req(250, 7, -1, "over_R1");       endtask
  task automatic t_engine_error();   run_req(10, 30, 1, "err_R9");         endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    ncmd = 0; total = 0; err_at = -1; need = 0; got = 0; wp_hi = 0;
    v_overlap = 0; v_rdy = 0; v_wp = 0; v_data = 0; v_stray = 0; v_rmw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(wp_n == 1'b0 && done == 1'b0 && cmd_valid == 1'b0 && req_ready == 1'b1,
          "reset R8/R11 state", int'(wp_n), 0);
    t_aligned_page();
    t_inside_page();
    t_cross_pages();
    t_whole_chip();
    t_zero_len();
    t_range_edge();
    t_range_over();
    t_engine_error();
    t_cross_pages();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule